// File: doc/BRIEF.md
# Single-Engine FFT Hilbert Transformer

This block takes one frame of real, signed Q1.15 samples and returns, for every sample, the Hilbert transform together with the real part of the analytic signal. It works in the frequency domain with a single radix-2 butterfly engine, used twice. The first pass produces the spectrum. A step-mask stage then zeroes the negative frequencies and doubles the positive ones. The second pass runs the same engine on the conjugated, masked spectrum, which gives the inverse transform. Both result streams come out in natural time order.

A transform is framed by a start pulse and a one-cycle done pulse. Samples enter with a valid/last pair while `in_ready` is high. Results leave with a valid/last pair and no back-pressure. From the last accepted sample to the first result the latency is fixed, and depends only on the frame length. Every butterfly stage halves its result, with rounding. The output stage undoes the combined scaling of both passes, then rounds and saturates to 16 bits.

Top module: `hilb_xform`

## Requirements
- R1: While reset is held and after its release, `in_ready`, `out_valid`, `out_last` and `done` are all low.
- R2: When `start` is high in an idle cycle, `in_ready` goes high on the next cycle and stays high until exactly N samples have been accepted (`in_valid` and `in_ready` both high at a clock edge). It then goes low. `in_valid` low cycles inside a frame only pause loading.
- R3: `start`, and `in_valid` while `in_ready` is low, are ignored during a transform. The results of the current frame are unchanged and no further frame is begun.
- R4: `out_hilb` for output n equals the imaginary part of z[n], within ±4 LSB. Here z is the inverse DFT of the masked DFT of the frame (R6), and every value is in Q1.15 (value/32768).
- R5: `out_real` for output n equals input sample n, within ±4 LSB.
- R6: In the mask, bin 0 and bin N/2 keep their value, bins 1..N/2-1 are doubled and bins N/2+1..N-1 become zero. A constant frame or an alternating ±a frame therefore gives `out_hilb` of zero and `out_real` equal to the input.
- R7: Results come in time order n = 0..N-1, with `out_valid` high on N consecutive cycles. `out_last` is high only with the N-th result.
- R8: The first result appears (`out_valid` high) after exactly N·log2(N) + N rising edges, counted from the edge that accepts the last input sample.
- R9: `done` is high for one cycle, the cycle after `out_last`. The block is then idle, and a `start` in that cycle is accepted.
- R10: A result beyond the Q1.15 range is saturated to 32767 or -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a transform when the block is idle |
| in_ready | output | 1 | High while frame samples are accepted |
| in_valid | input | 1 | Input sample valid |
| in_last | input | 1 | Marks the N-th sample of a frame |
| in_data | input | 16 | Input sample, signed Q1.15 |
| out_valid | output | 1 | Result valid |
| out_last | output | 1 | Marks the N-th result |
| out_real | output | 16 | Real part of analytic signal, signed Q1.15 |
| out_hilb | output | 16 | Hilbert transform, signed Q1.15 |
| done | output | 1 | One-cycle pulse after the last result |

## Verification
The overflow assertion assumes inputs lie within Q1.15. It also relies on the headroom given to internal words: log2(N) bits for each pass, plus two bits for the mask's doubling. The bench keeps every frame inside that range, and only one frame drives samples near full scale, where the analytic magnitude goes past one and saturation becomes visible. The `in_last` alignment check assumes the source marks exactly the N-th sample. Every frame in the bench does so, including the one with a pause inside the frame.

// File: rtl/hilb_pkg.sv
package hilb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_FWD, ST_MASK, ST_INV, ST_OUT
  } hstate_t;

  // reverse the low 'bits' bits of v
  function automatic int unsigned bitrev(input int unsigned v, input int unsigned bits);
    int unsigned r;
    r = 0;
    for (int unsigned i = 0; i < bits; i++) r = (r << 1) | ((v >> i) & 32'd1);
    return r;
  endfunction

  // quantised cos or sin of 2*pi*k/n with 'frac' fractional bits
  function automatic int tw_q(input int k, input int n, input int frac, input bit sine);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979 * real'(k) / real'(n);
    v = sine ? $sin(ang) : $cos(ang);
    return int'(v * real'(1 << frac));
  endfunction

endpackage

// File: rtl/hilb_twiddle.sv
module hilb_twiddle import hilb_pkg::*; #(
  parameter int N    = 1024,
  parameter int TW_W = 18
) (
  input  logic [$clog2(N)-2:0]    k,
  output logic signed [TW_W-1:0]  w_cos,
  output logic signed [TW_W-1:0]  w_sin
);
  localparam int HALF = N / 2;
  localparam int FRAC = TW_W - 2;

  logic signed [TW_W-1:0] cos_tab [HALF];
  logic signed [TW_W-1:0] sin_tab [HALF];

  for (genvar g = 0; g < HALF; g++) begin : g_tab
    assign cos_tab[g] = TW_W'(tw_q(g, N, FRAC, 1'b0));
    assign sin_tab[g] = TW_W'(tw_q(g, N, FRAC, 1'b1));
  end

  assign w_cos = cos_tab[k];
  assign w_sin = sin_tab[k];
endmodule

// File: rtl/hilb_bfly.sv
module hilb_bfly #(
  parameter int IW   = 30,
  parameter int TW_W = 18
) (
  input  logic signed [IW-1:0]   a_re,
  input  logic signed [IW-1:0]   a_im,
  input  logic signed [IW-1:0]   b_re,
  input  logic signed [IW-1:0]   b_im,
  input  logic signed [TW_W-1:0] w_cos,
  input  logic signed [TW_W-1:0] w_sin,
  output logic signed [IW-1:0]   x_re,
  output logic signed [IW-1:0]   x_im,
  output logic signed [IW-1:0]   y_re,
  output logic signed [IW-1:0]   y_im,
  output logic                   ovf
);
  localparam int FRAC = TW_W - 2;
  localparam int PW   = IW + TW_W;
  localparam logic signed [PW:0] P_HALF = (PW+1)'(1) <<< (FRAC - 1);

  function automatic logic signed [IW:0] scale_prod(input logic signed [PW:0] p);
    logic signed [PW:0] q;
    q = (p + P_HALF) >>> FRAC;
    return q[IW:0];
  endfunction

  function automatic logic signed [IW+1:0] halve(input logic signed [IW+1:0] s);
    return (s + (IW+2)'(1)) >>> 1;
  endfunction

  function automatic logic fits(input logic signed [IW+1:0] h);
    return (h[IW+1:IW-1] == 3'b000) || (h[IW+1:IW-1] == 3'b111);
  endfunction

  // t = b * (cos - j sin)
  logic signed [PW-1:0] p_rc, p_is, p_ic, p_rs;
  assign p_rc = b_re * w_cos;
  assign p_is = b_im * w_sin;
  assign p_ic = b_im * w_cos;
  assign p_rs = b_re * w_sin;

  logic signed [IW:0] t_re, t_im;
  assign t_re = scale_prod((PW+1)'(p_rc) + (PW+1)'(p_is));
  assign t_im = scale_prod((PW+1)'(p_ic) - (PW+1)'(p_rs));

  logic signed [IW+1:0] hx_re, hx_im, hy_re, hy_im;
  assign hx_re = halve((IW+2)'(a_re) + (IW+2)'(t_re));
  assign hx_im = halve((IW+2)'(a_im) + (IW+2)'(t_im));
  assign hy_re = halve((IW+2)'(a_re) - (IW+2)'(t_re));
  assign hy_im = halve((IW+2)'(a_im) - (IW+2)'(t_im));

  assign x_re = hx_re[IW-1:0];
  assign x_im = hx_im[IW-1:0];
  assign y_re = hy_re[IW-1:0];
  assign y_im = hy_im[IW-1:0];
  assign ovf  = !(fits(hx_re) && fits(hx_im) && fits(hy_re) && fits(hy_im));
endmodule

// File: rtl/hilb_ctrl.sv
module hilb_ctrl import hilb_pkg::*; #(
  parameter int N = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   in_valid,
  output hstate_t                st,
  output logic [$clog2(N)-1:0]   cnt,
  output logic [$clog2(N)-1:0]   i0,
  output logic [$clog2(N)-1:0]   i1,
  output logic [$clog2(N)-2:0]   twk,
  output logic                   in_ready,
  output logic                   out_valid,
  output logic                   out_last,
  output logic                   done
);
  localparam int L   = $clog2(N);
  localparam int TKW = L - 1;
  localparam int SW  = $clog2(L + 1);
  localparam int LAT = L * N + N;
  localparam logic [L-1:0]   CNT_LAST = '1;
  localparam logic [L-2:0]   BF_LAST  = '1;
  localparam logic [SW-1:0]  STG_LAST = SW'(L - 1);

  logic [SW-1:0] stage;
  logic [L-2:0]  bf;

  // butterfly addresses for decimation in time, bit-reversed input
  always_comb begin
    int unsigned bi, si, msk, base;
    bi   = 32'(bf);
    si   = 32'(stage);
    msk  = (32'd1 << si) - 32'd1;
    base = ((bi >> si) << (si + 32'd1)) | (bi & msk);
    i0   = L'(base);
    i1   = L'(base | (32'd1 << si));
    twk  = TKW'((bi & msk) << (32'(L - 1) - si));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      stage <= '0;
      bf    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) st <= ST_LOAD;
        ST_LOAD: if (in_valid) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) st <= ST_FWD;
        end
        ST_FWD, ST_INV: begin
          bf <= bf + 1'b1;
          if (bf == BF_LAST) begin
            if (stage == STG_LAST) begin
              stage <= '0;
              st    <= (st == ST_FWD) ? ST_MASK : ST_OUT;
            end else begin
              stage <= stage + 1'b1;
            end
          end
        end
        ST_MASK: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) st <= ST_INV;
        end
        ST_OUT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (st == ST_LOAD);
  assign out_valid = (st == ST_OUT);
  assign out_last  = out_valid && (cnt == CNT_LAST);

  // latency window counted independently of the pass counters
  logic [31:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= '0;
    else if (in_ready && in_valid && cnt == CNT_LAST) lat_cnt <= 32'd1;
    else if (out_last) lat_cnt <= '0;
    else if (lat_cnt != 0 && !out_valid) lat_cnt <= lat_cnt + 32'd1;
  end

  assert_ready_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(start));
  assert_ready_drops_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid && cnt == CNT_LAST) |=> !in_ready);
  assert_fixed_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == 32'(LAT + 1)));
  assert_burst_contiguous_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);
  assert_done_follows_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> (done && !out_valid));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/hilb_xform.sv
module hilb_xform import hilb_pkg::*; #(
  parameter int N      = 1024,
  parameter int DATA_W = 16,
  parameter int TW_W   = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     in_ready,
  input  logic                     in_valid,
  input  logic                     in_last,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic                     out_last,
  output logic signed [DATA_W-1:0] out_real,
  output logic signed [DATA_W-1:0] out_hilb,
  output logic                     done
);
  localparam int L  = $clog2(N);
  localparam int IW = DATA_W + 2 * L + 2;
  localparam logic [L-1:0]        NYQ  = {1'b1, {(L-1){1'b0}}};
  localparam logic [L-1:0]        LAST = '1;
  localparam logic signed [IW:0]  RND  = (IW+1)'(1) <<< (L - 1);
  localparam logic signed [IW:0]  MAXV = (IW+1)'((1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [IW:0]  MINV = -((IW+1)'(1) <<< (DATA_W - 1));
  localparam logic signed [DATA_W-1:0] MAXQ = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MINQ = {1'b1, {(DATA_W-1){1'b0}}};

  // step mask: DC and Nyquist kept, positive bins doubled, negative bins cleared
  function automatic logic signed [IW-1:0] weigh(input logic signed [IW-1:0] v,
                                                 input logic [L-1:0] bin);
    if (bin == '0 || bin == NYQ) return v;
    else if (bin < NYQ)          return v <<< 1;
    else                         return '0;
  endfunction

  // undo 2^-2L scaling against the 2^2L input shift, round, saturate
  function automatic logic signed [DATA_W-1:0] to_q15(input logic signed [IW:0] v);
    logic signed [IW:0] r;
    r = (v + RND) >>> L;
    if (r > MAXV) return MAXQ;
    if (r < MINV) return MINQ;
    return r[DATA_W-1:0];
  endfunction

  hstate_t        st;
  logic [L-1:0]   cnt, i0, i1, rev, ra, rb;
  logic [L-2:0]   twk;

  hilb_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .st(st), .cnt(cnt), .i0(i0), .i1(i1), .twk(twk),
    .in_ready(in_ready), .out_valid(out_valid), .out_last(out_last), .done(done)
  );

  logic signed [TW_W-1:0] w_cos, w_sin;
  hilb_twiddle #(.N(N), .TW_W(TW_W)) u_tw (.k(twk), .w_cos(w_cos), .w_sin(w_sin));

  logic signed [IW-1:0] mem_re [N];
  logic signed [IW-1:0] mem_im [N];

  assign rev = L'(bitrev(32'(cnt), L));
  assign ra  = (st == ST_MASK || st == ST_OUT) ? cnt : i0;
  assign rb  = (st == ST_MASK) ? rev : i1;

  logic signed [IW-1:0] a_re, a_im, b_re, b_im;
  assign a_re = mem_re[ra];
  assign a_im = mem_im[ra];
  assign b_re = mem_re[rb];
  assign b_im = mem_im[rb];

  logic signed [IW-1:0] x_re, x_im, y_re, y_im;
  logic                 bf_ovf;
  hilb_bfly #(.IW(IW), .TW_W(TW_W)) u_bfly (
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .w_cos(w_cos), .w_sin(w_sin),
    .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im), .ovf(bf_ovf)
  );

  logic signed [IW-1:0] ld_val;
  logic [L-1:0]         ld_addr;
  assign ld_val  = IW'(in_data) <<< (2 * L);
  assign ld_addr = rev;

  always_ff @(posedge clk) begin
    case (st)
      ST_LOAD: if (in_valid) begin
        mem_re[ld_addr] <= ld_val;
        mem_im[ld_addr] <= '0;
      end
      ST_FWD, ST_INV: begin
        mem_re[i0] <= x_re;
        mem_im[i0] <= x_im;
        mem_re[i1] <= y_re;
        mem_im[i1] <= y_im;
      end
      ST_MASK: if (cnt <= rev) begin
        // mask, conjugate and bit-reverse in one swap
        mem_re[rev] <= weigh(a_re, cnt);
        mem_im[rev] <= -weigh(a_im, cnt);
        mem_re[cnt] <= weigh(b_re, rev);
        mem_im[cnt] <= -weigh(b_im, rev);
      end
      default: ;
    endcase
  end

  // inverse result is conjugated on the way out
  assign out_real = to_q15((IW+1)'(a_re));
  assign out_hilb = to_q15(-((IW+1)'(a_im)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FWD || st == ST_INV) |-> !bf_ovf);
  assert_last_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid && in_last) |-> (cnt == LAST));
  assert_no_output_while_loading_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);
endmodule

// File: tb/hilb_xform_tb.sv
module hilb_xform_tb;
  localparam int N   = 64;
  localparam int L   = 6;
  localparam int TOL = 4;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic signed [15:0] in_data = '0;
  logic in_ready, out_valid, out_last, done;
  logic signed [15:0] out_real, out_hilb;

  always #4 clk = ~clk;

  hilb_xform #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
    .in_valid(in_valid), .in_last(in_last), .in_data(in_data),
    .out_valid(out_valid), .out_last(out_last), .out_real(out_real),
    .out_hilb(out_hilb), .done(done)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int frame [N];
  int exp_re_q[$], exp_im_q[$];
  string tag_q[$];

  // behavioural control model: 0 idle, 1 loading, 2 busy, 3 emitting
  int mphase = 0, mcnt = 0;
  bit mdone = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mphase = 0; mcnt = 0; mdone = 0;
    end else begin
      mdone = 0;
      case (mphase)
        0: if (start) begin mphase = 1; mcnt = 0; end
        1: if (in_valid) begin
             if (mcnt == N - 1) begin mphase = 2; mcnt = 0; end else mcnt++;
           end
        2: begin mcnt++; if (mcnt == L * N + N) begin mphase = 3; mcnt = 0; end end
        default: if (mcnt == N - 1) begin mdone = 1; mphase = 0; mcnt = 0; end else mcnt++;
      endcase
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic chk_tol(input int act, input int exp, input string what);
    int d;
    checks++;
    d = act - exp;
    if (d > TOL || d < -TOL) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(int'(in_ready), int'(mphase == 1), "R2 R3 in_ready");
      chk(int'(out_valid), int'(mphase == 3), "R8 R7 out_valid");
      chk(int'(out_last), int'(mphase == 3 && mcnt == N - 1), "R7 out_last");
      chk(int'(done), int'(mdone), "R9 done");
      if (out_valid) begin
        if (exp_re_q.size() == 0) chk(1, 0, "R3 unexpected result");
        else begin
          string t;
          t = tag_q.pop_front();
          chk_tol(int'(out_real), exp_re_q.pop_front(), {t, " R5 real"});
          chk_tol(int'(out_hilb), exp_im_q.pop_front(), {t, " R4 hilbert"});
        end
      end
    end
  end

  function automatic int q15(input real r);
    int v;
    v = int'(r * 32768.0);
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  // ideal analytic signal from a direct DFT
  task automatic compute_expected(input string tag);
    real xr [N];
    real fr [N];
    real fi [N];
    for (int n = 0; n < N; n++) xr[n] = real'(frame[n]) / 32768.0;
    for (int k = 0; k < N; k++) begin
      fr[k] = 0.0; fi[k] = 0.0;
      for (int n = 0; n < N; n++) begin
        real th;
        th = 2.0 * PI * real'((k * n) % N) / real'(N);
        fr[k] += xr[n] * $cos(th);
        fi[k] -= xr[n] * $sin(th);
      end
    end
    for (int n = 0; n < N; n++) begin
      real zr, zi;
      zr = 0.0; zi = 0.0;
      for (int k = 0; k < N; k++) begin
        real th, w;
        th = 2.0 * PI * real'((k * n) % N) / real'(N);
        w = (k == 0 || k == N / 2) ? 1.0 : ((k < N / 2) ? 2.0 : 0.0);
        zr += w * (fr[k] * $cos(th) - fi[k] * $sin(th));
        zi += w * (fr[k] * $sin(th) + fi[k] * $cos(th));
      end
      exp_re_q.push_back(q15(zr / real'(N)));
      exp_im_q.push_back(q15(zi / real'(N)));
      tag_q.push_back(tag);
    end
  endtask

  task automatic send_frame(input string tag, input bit junk, input int gap, input bit b2b);
    if (!b2b) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    compute_expected(tag);
    for (int i = 0; i < N; i++) begin
      if (gap > 0 && i == N / 2) begin
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = 16'(frame[i]);
      in_last  = (i == N - 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    if (junk) begin
      // R3: stray start and samples during the transform
      in_valid = 1'b1; start = 1'b1; in_data = 16'sh7abc;
      while (!out_valid) @(negedge clk);
      in_valid = 1'b0; start = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  task automatic report;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    chk(int'(in_ready), 0, "R1 in_ready in reset");
    chk(int'(out_valid), 0, "R1 out_valid in reset");
    chk(int'(out_last), 0, "R1 out_last in reset");
    chk(int'(done), 0, "R1 done in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int n = 0; n < N; n++) frame[n] = int'(16384.0 * $sin(2.0 * PI * 4.0 * n / N));
    send_frame("sine", 1'b0, 0, 1'b0);

    for (int n = 0; n < N; n++)
      frame[n] = int'(9000.0 * $cos(2.0 * PI * 3.0 * n / N) + 7000.0 * $sin(2.0 * PI * 11.0 * n / N));
    send_frame("two-tone R7 pause", 1'b0, 5, 1'b0);

    for (int n = 0; n < N; n++) frame[n] = 9830;
    send_frame("R6 dc", 1'b0, 0, 1'b0);

    for (int n = 0; n < N; n++) frame[n] = (n % 2 == 0) ? 13107 : -13107;
    send_frame("R6 nyquist R9 back-to-back", 1'b0, 0, 1'b1);

    seed = 12345;
    for (int n = 0; n < N; n++) begin
      seed = seed * 1103515245 + 12345;
      frame[n] = ((seed >>> 8) % 9830);
    end
    send_frame("R3 random with stray inputs", 1'b1, 0, 1'b0);

    for (int n = 0; n < N; n++) frame[n] = ((n / 8) % 2 == 0) ? 32700 : -32700;
    send_frame("R10 square saturating", 1'b0, 0, 1'b0);

    repeat (4) @(negedge clk);
    chk(exp_re_q.size(), 0, "R7 all results delivered");
    report();
  end
endmodule